// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit takes the address field, register selector and mode code of one instruction and resolves the operand. For some modes it computes an effective address (EA) and then reads the operand from memory. For others it returns a value directly, with no memory traffic. It uses a single-ported synchronous memory read channel and a combinational register-file read port. Accesses are sequenced one at a time, so pointer chains of one to three levels are walked read by read.

A request is a one-cycle `start` pulse while the unit is idle. The fields are captured on that edge. The register file is read in the following cycle. When the operand (and the EA, where one exists) is ready, the unit raises `done` for one cycle. Results stay on `ea` and `operand` until the next completion.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done`, `err` and `mem_re` are low.
- R2: Mode 0 (immediate) returns `operand` = A and `ea` = 0, issues no memory read, and raises `done` 1 edge after the start edge.
- R3: Mode 1 (direct) returns `ea` = A and `operand` = memory word at A, with exactly one read, and `done` 3 edges after the start edge.
- R4: Mode 2 (indirect) performs d pointer reads and then one operand read. Here d is the 2-bit depth code, and code 0 counts as 1. Each pointer read uses the previous word as its address, starting at A. `ea` is the last pointer word, and `done` comes 3+2d edges after the start edge.
- R5: Mode 3 (register) returns `operand` = contents of register R and `ea` = 0, issues no memory read, and raises `done` 1 edge after the start edge.
- R6: Mode 4 (register indirect) uses `ea` = contents of R, with one read, and `done` 3 edges after the start edge.
- R7: Modes 5 (displacement), 7 (base register) and 8 (indexed) use `ea` = A + contents of R, modulo 2^32, with one read, and `done` 3 edges after the start edge.
- R8: Mode 6 (relative) uses `ea` = A + `pc` as captured at start, modulo 2^32, with one read, and `done` 3 edges after the start edge.
- R9: Mode codes 9 to 15 raise `err` together with `done` 1 edge after the start edge, with no memory read, and `ea` = `operand` = 0.
- R10: A `start` pulse while the unit is busy is ignored. It produces no extra completion and does not alter the result in progress.
- R11: Each read request is a single-cycle `mem_re` pulse, and the next read is issued only after the previous data has returned.
- R12: `done` is a one-cycle pulse, and `ea` and `operand` hold their values after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken when idle |
| mode | input | 4 | Addressing mode code |
| depth | input | 2 | Indirection levels (0 treated as 1) |
| addr_a | input | 32 | Instruction address field A |
| reg_sel | input | 4 | Register field R |
| pc | input | 32 | Program counter value |
| rf_addr | output | 4 | Register-file read index |
| rf_data | input | 32 | Register-file read data, same cycle |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Read data, valid the cycle after the strobe cycle |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Unsupported mode, with done |
| ea | output | 32 | Effective address result |
| operand | output | 32 | Operand result |

## Verification
The latency is counted in clock edges after the edge that samples `start`:

| Modes | Edges to `done` |
|---|---|
| Immediate, register, unsupported | 1 |
| Single-read modes | 3 |
| Indirect at depth d | 3+2d |

The driver records the start cycle and pushes that due cycle with each expected item. The monitor samples on the falling edge and rejects a completion that arrives in any other cycle. It also counts read strobes between completions and compares them with the expected count, so stray or early reads are caught as well as wrong values.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam logic [3:0] MD_IMM  = 4'd0;
  localparam logic [3:0] MD_DIR  = 4'd1;
  localparam logic [3:0] MD_IND  = 4'd2;
  localparam logic [3:0] MD_REG  = 4'd3;
  localparam logic [3:0] MD_RIND = 4'd4;
  localparam logic [3:0] MD_DISP = 4'd5;
  localparam logic [3:0] MD_REL  = 4'd6;
  localparam logic [3:0] MD_BASE = 4'd7;
  localparam logic [3:0] MD_IDX  = 4'd8;

  // how a mode resolves its operand
  typedef enum logic [1:0] {
    K_VAL,   // value returned without memory access
    K_MEM,   // one operand read at computed EA
    K_PTR,   // pointer chain then operand read
    K_BAD    // unsupported code
  } kind_e;

  // source of the computed address
  typedef enum logic [1:0] {
    AS_A,
    AS_REG,
    AS_A_REG,
    AS_A_PC
  } asel_e;

  typedef struct packed {
    kind_e kind;
    asel_e asel;
    logic  val_reg;   // K_VAL returns register contents instead of A
  } dec_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CALC,
    S_ISSUE,
    S_WAIT
  } st_e;

endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
  import ea_pkg::*;
(
  input  logic [3:0] mode,
  output dec_t       dec
);

  always_comb begin
    dec = '{kind: K_BAD, asel: AS_A, val_reg: 1'b0};
    case (mode)
      MD_IMM:  dec = '{kind: K_VAL, asel: AS_A,     val_reg: 1'b0};
      MD_DIR:  dec = '{kind: K_MEM, asel: AS_A,     val_reg: 1'b0};
      MD_IND:  dec = '{kind: K_PTR, asel: AS_A,     val_reg: 1'b0};
      MD_REG:  dec = '{kind: K_VAL, asel: AS_A,     val_reg: 1'b1};
      MD_RIND: dec = '{kind: K_MEM, asel: AS_REG,   val_reg: 1'b0};
      MD_DISP: dec = '{kind: K_MEM, asel: AS_A_REG, val_reg: 1'b0};
      MD_REL:  dec = '{kind: K_MEM, asel: AS_A_PC,  val_reg: 1'b0};
      MD_BASE: dec = '{kind: K_MEM, asel: AS_A_REG, val_reg: 1'b0};
      MD_IDX:  dec = '{kind: K_MEM, asel: AS_A_REG, val_reg: 1'b0};
      default: dec = '{kind: K_BAD, asel: AS_A,     val_reg: 1'b0};
    endcase
  end

endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int DW = 32
) (
  input  asel_e          asel,
  input  logic           val_reg,
  input  logic [DW-1:0]  fld_a,
  input  logic [DW-1:0]  reg_val,
  input  logic [DW-1:0]  pc_val,
  output logic [DW-1:0]  ea_calc,
  output logic [DW-1:0]  val_calc
);

  // one shared adder; second input chosen by mode, wraps modulo 2^DW
  logic [DW-1:0] add_b;

  always_comb begin
    add_b = (asel == AS_A_PC) ? pc_val : reg_val;
    case (asel)
      AS_A:    ea_calc = fld_a;
      AS_REG:  ea_calc = reg_val;
      default: ea_calc = fld_a + add_b;
    endcase
    val_calc = val_reg ? reg_val : fld_a;
  end

endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  dec_t           dec,
  input  logic [LW-1:0]  depth,
  input  logic [DW-1:0]  ea_calc,
  input  logic [DW-1:0]  val_calc,
  input  logic [DW-1:0]  mem_rdata,
  output logic           accept,
  output logic           busy,
  output logic           mem_re,
  output logic [DW-1:0]  mem_addr,
  output logic           done,
  output logic           err,
  output logic [DW-1:0]  ea,
  output logic [DW-1:0]  operand
);

  st_e           st_q, st_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          re_d, done_d, err_d;
  logic [DW-1:0] addr_d, ea_d, opnd_d;

  assign busy   = (st_q != S_IDLE);
  assign accept = start && !busy;

  always_comb begin
    st_d   = st_q;
    lvl_d  = lvl_q;
    re_d   = 1'b0;
    addr_d = mem_addr;
    done_d = 1'b0;
    err_d  = 1'b0;
    ea_d   = ea;
    opnd_d = operand;
    case (st_q)
      S_IDLE: if (accept) st_d = S_CALC;
      S_CALC: begin
        case (dec.kind)
          K_VAL: begin
            done_d = 1'b1;
            opnd_d = val_calc;
            ea_d   = '0;
            st_d   = S_IDLE;
          end
          K_MEM: begin
            re_d   = 1'b1;
            addr_d = ea_calc;
            ea_d   = ea_calc;
            lvl_d  = '0;
            st_d   = S_ISSUE;
          end
          K_PTR: begin
            re_d   = 1'b1;
            addr_d = ea_calc;
            lvl_d  = (depth == '0) ? LW'(1) : depth;
            st_d   = S_ISSUE;
          end
          default: begin
            done_d = 1'b1;
            err_d  = 1'b1;
            opnd_d = '0;
            ea_d   = '0;
            st_d   = S_IDLE;
          end
        endcase
      end
      S_ISSUE: st_d = S_WAIT;
      S_WAIT: begin
        if (lvl_q != '0) begin
          // returned word is the next pointer
          lvl_d  = lvl_q - LW'(1);
          re_d   = 1'b1;
          addr_d = mem_rdata;
          ea_d   = mem_rdata;
          st_d   = S_ISSUE;
        end else begin
          done_d = 1'b1;
          opnd_d = mem_rdata;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      lvl_q    <= '0;
      mem_re   <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      ea       <= '0;
      operand  <= '0;
    end else begin
      st_q     <= st_d;
      lvl_q    <= lvl_d;
      mem_re   <= re_d;
      mem_addr <= addr_d;
      done     <= done_d;
      err      <= err_d;
      ea       <= ea_d;
      operand  <= opnd_d;
    end
  end

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RSW = 4,
  parameter int MW  = 4,
  parameter int LW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MW-1:0]   mode,
  input  logic [LW-1:0]   depth,
  input  logic [DW-1:0]   addr_a,
  input  logic [RSW-1:0]  reg_sel,
  input  logic [DW-1:0]   pc,
  output logic [RSW-1:0]  rf_addr,
  input  logic [DW-1:0]   rf_data,
  output logic            mem_re,
  output logic [DW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  output logic            done,
  output logic            err,
  output logic [DW-1:0]   ea,
  output logic [DW-1:0]   operand
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  // request fields captured on acceptance
  logic            accept, busy;
  logic [MW-1:0]   mode_q;
  logic [LW-1:0]   depth_q;
  logic [DW-1:0]   a_q, pc_q;
  logic [RSW-1:0]  reg_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mode_q  <= '0;
      depth_q <= '0;
      a_q     <= '0;
      pc_q    <= '0;
      reg_q   <= '0;
    end else if (accept) begin
      mode_q  <= mode;
      depth_q <= depth;
      a_q     <= addr_a;
      pc_q    <= pc;
      reg_q   <= reg_sel;
    end
  end

  assign rf_addr = reg_q;

  dec_t          dec;
  logic [DW-1:0] ea_calc, val_calc;

  ea_mode_dec u_dec (
    .mode (mode_q),
    .dec  (dec)
  );

  ea_addr_gen #(.DW(DW)) u_gen (
    .asel     (dec.asel),
    .val_reg  (dec.val_reg),
    .fld_a    (a_q),
    .reg_val  (rf_data),
    .pc_val   (pc_q),
    .ea_calc  (ea_calc),
    .val_calc (val_calc)
  );

  ea_seq #(.DW(DW), .LW(LW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start),
    .dec       (dec),
    .depth     (depth_q),
    .ea_calc   (ea_calc),
    .val_calc  (val_calc),
    .mem_rdata (mem_rdata),
    .accept    (accept),
    .busy      (busy),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .done      (done),
    .err       (err),
    .ea        (ea),
    .operand   (operand)
  );

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [3:0]    mode,
  input logic [DW-1:0] addr_a,
  input logic          busy,
  input logic          mem_re,
  input logic          done,
  input logic          err,
  input logic [DW-1:0] operand
);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R11
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);

  // R2
  imm_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 4'd0) |=> ##1 (done && operand == $past(addr_a, 2)));

  // R5
  reg_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 4'd3) |=> (!mem_re ##1 (done && !mem_re)));

  // R9
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode > 4'd8) |=> ##1 (done && err && !mem_re));

  // R10
  busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !done);

endmodule

bind ea_unit ea_unit_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .mode    (mode),
  .addr_a  (addr_a),
  .busy    (busy),
  .mem_re  (mem_re),
  .done    (done),
  .err     (err),
  .operand (operand)
);

// File: tb/ea_unit_tb.sv
module ea_unit_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  mode;
  logic [1:0]  depth;
  logic [31:0] addr_a, pc;
  logic [3:0]  reg_sel, rf_addr;
  logic [31:0] rf_data, mem_addr, mem_rdata, ea, operand;
  logic        mem_re, done, err;

  always #2.5 clk = ~clk;

  ea_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .depth(depth),
    .addr_a(addr_a), .reg_sel(reg_sel), .pc(pc), .rf_addr(rf_addr),
    .rf_data(rf_data), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done(done), .err(err), .ea(ea), .operand(operand)
  );

  // models of memory and register file
  logic [31:0] mem [256];
  logic [31:0] regs [16];
  assign rf_data = regs[rf_addr];
  always @(posedge clk) if (mem_re) mem_rdata <= mem[mem_addr[7:0]];

  typedef struct {
    logic [31:0] ea;
    logic [31:0] op;
    logic        err;
    int          reads;
    int          due;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   nchk = 0;
  int   nbad = 0;
  int   reads_seen = 0;
  logic prev_done = 1'b0;
  logic [31:0] last_ea, last_op;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) begin
        chk(!done, "R12", "done longer than one cycle", {31'b0, done}, 32'd0);
        chk(ea == last_ea && operand == last_op, "R12", "hold after done", ea, last_ea);
      end
      if (mem_re) reads_seen++;
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected completion", {31'b0, done}, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.due, e.req, "done cycle", cyc, e.due);
          chk(ea == e.ea, e.req, "ea", ea, e.ea);
          chk(operand == e.op, e.req, "operand", operand, e.op);
          chk(err == e.err, e.req, "err", {31'b0, err}, {31'b0, e.err});
          chk(reads_seen == e.reads, "R11", "read count", reads_seen, e.reads);
        end
        reads_seen = 0;
        last_ea = ea;
        last_op = operand;
      end
      prev_done = done;
    end
  end

  // driver: computes the expectation, pushes it, pulses start
  task automatic apply(input logic [3:0] m, input logic [1:0] d, input logic [31:0] a,
                       input logic [3:0] r, input logic [31:0] p, input string req,
                       input int hold = 1);
    exp_t e;
    logic [31:0] ptr;
    int lat;
    int dd;
    e.err = 1'b0; e.ea = '0; e.op = '0; e.reads = 1; lat = 3; e.req = req;
    case (m)
      4'd0: begin e.op = a; e.reads = 0; lat = 1; end
      4'd1: begin e.ea = a; end
      4'd2: begin
        dd = (d == 2'd0) ? 1 : int'(d);
        ptr = a;
        for (int i = 0; i < dd; i++) ptr = mem[ptr[7:0]];
        e.ea = ptr; e.reads = dd + 1; lat = 3 + 2 * dd;
      end
      4'd3: begin e.op = regs[r]; e.reads = 0; lat = 1; end
      4'd4: e.ea = regs[r];
      4'd5, 4'd7, 4'd8: e.ea = a + regs[r];
      4'd6: e.ea = a + p;
      default: begin e.err = 1'b1; e.reads = 0; lat = 1; end
    endcase
    if (e.reads > 0) e.op = mem[e.ea[7:0]];
    @(negedge clk);
    mode = m; depth = d; addr_a = a; reg_sel = r; pc = p; start = 1'b1;
    e.due = cyc + 1 + lat;
    q.push_back(e);
    for (int k = 1; k < hold; k++) begin
      @(negedge clk);
      mode = 4'd0; addr_a = 32'hDEAD_0000 + k; reg_sel = 4'd9; pc = 32'h0;
    end
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = {8'hC3, 16'(i * 13), 8'((i * 29 + 7) & 255)};
    for (int i = 0; i < 16; i++) regs[i] = i * 32'h0111_0011 + 32'd5;
    regs[15] = 32'hFFFF_FFF8;
    start = 1'b0; mode = '0; depth = '0; addr_a = '0; reg_sel = '0; pc = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !err && !mem_re, "R1", "reset outputs", {29'b0, done, err, mem_re}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !err && !mem_re, "R1", "idle after reset", {29'b0, done, err, mem_re}, 32'd0);

    apply(4'd0, 2'd0, 32'h1234_5678, 4'd0, 32'd0, "R2");
    apply(4'd1, 2'd0, 32'h0000_0020, 4'd0, 32'd0, "R3");
    apply(4'd2, 2'd1, 32'h0000_0005, 4'd0, 32'd0, "R4");
    apply(4'd2, 2'd2, 32'h0000_0040, 4'd0, 32'd0, "R4");
    apply(4'd2, 2'd3, 32'h0000_007F, 4'd0, 32'd0, "R4");
    apply(4'd2, 2'd0, 32'h0000_0011, 4'd0, 32'd0, "R4");
    apply(4'd3, 2'd0, 32'h0000_0099, 4'd3, 32'd0, "R5");
    apply(4'd4, 2'd0, 32'h0000_0000, 4'd2, 32'd0, "R6");
    apply(4'd5, 2'd0, 32'h0000_0030, 4'd4, 32'd0, "R7");
    apply(4'd5, 2'd0, 32'hFFFF_FFF0, 4'd15, 32'd0, "R7");
    apply(4'd7, 2'd0, 32'h0000_0008, 4'd6, 32'd0, "R7");
    apply(4'd8, 2'd0, 32'h0000_0200, 4'd1, 32'd0, "R7");
    apply(4'd6, 2'd0, 32'h0000_0010, 4'd0, 32'h0000_0100, "R8");
    apply(4'd6, 2'd0, 32'h8000_0000, 4'd0, 32'h8000_0004, "R8");
    apply(4'd9, 2'd0, 32'h0000_0001, 4'd0, 32'd0, "R9");
    apply(4'd15, 2'd3, 32'h0000_0002, 4'd0, 32'd0, "R9");
    // R10: start held through busy cycles with other fields
    apply(4'd1, 2'd0, 32'h0000_0033, 4'd0, 32'd0, "R10", 3);
    apply(4'd2, 2'd2, 32'h0000_0021, 4'd0, 32'd0, "R10", 5);

    repeat (10) @(negedge clk);
    chk(q.size() == 0 && !done, "R10", "no stray completion", q.size(), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule